// File: doc/BRIEF.md
# Fast Context Switch Address Remapper

This block sits between a processor's address generation and its memory management unit. It holds a small process identifier and uses it to move low virtual addresses into a per-process slot. Any address whose top identifier-width bits are all zero falls inside the lowest window. Such an address is relocated by adding the identifier times the window size. Every other address goes through untouched. With the default widths the window is 32 MB and there are 128 slots. The output address is registered, so it appears one cycle after the input.

The identifier is reached through a coprocessor-style access port that carries a four-part selector. It answers only to primary 13, secondary 0, op1 0 and op2 0, and only from privileged software. There is one identifier copy per security world. An access picks its copy with a world bit, and the translation path picks its copy with a separate world bit. A lock input stops secure-world writes and reports them as undefined. Each accepted write raises a one-cycle flush request, so that the surrounding pipeline can refetch with the new mapping.

Top module: `ctx_slot_remap`

## Requirements
- R1: After a synchronous reset both identifier copies are zero, so every address maps to itself. `rd_valid`, `undef` and `flush_req` are low.
- R2: When `va_in[31:25]` is zero, `mva_out` equals `va_in` plus the selected identifier times 2^25. This is the same as replacing bits 31:25 with the identifier. `mva_out` appears on the cycle after `va_in` is presented.
- R3: When any of `va_in[31:25]` is set, `mva_out` equals `va_in`, one cycle later, whatever the identifier is.
- R4: A privileged write with selector (13,0,0,0) loads `acc_wdata[31:25]` into the copy chosen by `acc_nonsec` (1 selects the nonsecure copy). Translation uses the copy chosen by `va_nonsec`, and the other copy is left unchanged.
- R5: A privileged read with selector (13,0,0,0) gives `rd_valid` high for one cycle on the next cycle. With it, `rd_data` holds the chosen copy in bits 31:25 and zero in bits 24:0.
- R6: An access with the matching selector and `acc_priv` low raises `undef` for one cycle. It stores nothing and gives no `rd_valid` and no `flush_req`.
- R7: While `sec_lock` is high, a privileged write to the secure copy (`acc_nonsec`=0) raises `undef` and stores nothing. Nonsecure writes and all reads still complete.
- R8: `flush_req` is high for exactly the cycle after each accepted write. Rejected writes and reads never raise it.
- R9: An access with any other selector value changes no copy and raises none of `rd_valid`, `undef` or `flush_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Register access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_crn | input | 4 | Primary selector |
| acc_crm | input | 4 | Secondary selector |
| acc_op1 | input | 3 | First opcode selector |
| acc_op2 | input | 3 | Second opcode selector |
| acc_priv | input | 1 | Access comes from a privileged mode |
| acc_nonsec | input | 1 | Access targets the nonsecure copy |
| acc_wdata | input | 32 | Write data; identifier in bits 31:25 |
| sec_lock | input | 1 | Blocks writes to the secure copy |
| va_in | input | 32 | Virtual address to remap |
| va_nonsec | input | 1 | Translation uses the nonsecure copy |
| mva_out | output | 32 | Remapped address, registered |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 32 | Read data, identifier in bits 31:25 |
| undef | output | 1 | Undefined-access pulse |
| flush_req | output | 1 | Pipeline flush request pulse |

## Verification
The bench builds the block with its default widths: 32-bit addresses and a 7-bit identifier. With these widths every one of the 128 slots can be swept, each writing a slot number and translating the top byte of the window. The edge addresses 0x01FFFFFF and 0x02000000 sit exactly on the relocation boundary. The largest identifier, 127, exercises the carry-free top of the address space. Separate world bits on the access and translation paths let the bench show that one copy changes while the other keeps its value.

// File: rtl/ctx_remap_pkg.sv
package ctx_remap_pkg;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2,
    ACC_FAULT = 2'd3
  } acc_kind_e;

  localparam int WORLDS = 2;

  localparam logic [3:0] SEL_PRI = 4'd13;
  localparam logic [3:0] SEL_SEC = 4'd0;
  localparam logic [2:0] SEL_OP1 = 3'd0;
  localparam logic [2:0] SEL_OP2 = 3'd0;

endpackage

// File: rtl/ctx_access_decode.sv
module ctx_access_decode
  import ctx_remap_pkg::*;
(
  input  logic      valid,
  input  logic      write,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] op1,
  input  logic [2:0] op2,
  input  logic      priv,
  input  logic      nonsec,
  input  logic      lock,
  output acc_kind_e kind
);

  logic sel_hit;
  logic lock_hit;

  assign sel_hit  = valid && (crn == SEL_PRI) && (crm == SEL_SEC) &&
                    (op1 == SEL_OP1) && (op2 == SEL_OP2);
  assign lock_hit = write && lock && !nonsec;

  always_comb begin
    if (!sel_hit)             kind = ACC_NONE;
    else if (!priv)           kind = ACC_FAULT;
    else if (lock_hit)        kind = ACC_FAULT;
    else if (write)           kind = ACC_WRITE;
    else                      kind = ACC_READ;
  end

endmodule

// File: rtl/ctx_id_bank.sv
module ctx_id_bank
  import ctx_remap_pkg::*;
#(
  parameter int PID_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_world,
  input  logic [PID_W-1:0] wr_pid,
  input  logic             acc_world,
  input  logic             xl_world,
  output logic [PID_W-1:0] acc_pid,
  output logic [PID_W-1:0] xl_pid
);

  logic [PID_W-1:0] copy_q [WORLDS];

  for (genvar w = 0; w < WORLDS; w++) begin : g_world
    always_ff @(posedge clk) begin
      if (rst)
        copy_q[w] <= '0;
      else if (wr_en && (wr_world == w[0]))
        copy_q[w] <= wr_pid;
    end

    AST_COPY_HOLD: assert property (@(posedge clk) disable iff (rst)
      !$past(wr_en && (wr_world == w[0])) |-> $stable(copy_q[w])); // R4
  end

  assign acc_pid = copy_q[acc_world];
  assign xl_pid  = copy_q[xl_world];

endmodule

// File: rtl/ctx_addr_xlate.sv
module ctx_addr_xlate #(
  parameter int ADDR_W = 32,
  parameter int PID_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] va,
  input  logic [PID_W-1:0]  pid,
  output logic [ADDR_W-1:0] mva
);

  localparam int WIN_W = ADDR_W - PID_W;

  logic in_window;
  assign in_window = (va[ADDR_W-1 -: PID_W] == '0);

  always_ff @(posedge clk) begin
    if (rst)
      mva <= '0;
    else if (in_window)
      mva <= {pid, va[WIN_W-1:0]};
    else
      mva <= va;
  end

  AST_HIGH_PASS: assert property (@(posedge clk) disable iff (rst)
    ($past(va[ADDR_W-1 -: PID_W]) != '0) |-> (mva == $past(va))); // R3

  AST_LOW_OFFSET: assert property (@(posedge clk) disable iff (rst)
    ($past(va[ADDR_W-1 -: PID_W]) == '0) |-> (mva[WIN_W-1:0] == $past(va[WIN_W-1:0]))); // R2

endmodule

// File: rtl/ctx_slot_remap.sv
module ctx_slot_remap
  import ctx_remap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PID_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [3:0]        acc_crn,
  input  logic [3:0]        acc_crm,
  input  logic [2:0]        acc_op1,
  input  logic [2:0]        acc_op2,
  input  logic              acc_priv,
  input  logic              acc_nonsec,
  input  logic [ADDR_W-1:0] acc_wdata,
  input  logic              sec_lock,
  input  logic [ADDR_W-1:0] va_in,
  input  logic              va_nonsec,
  output logic [ADDR_W-1:0] mva_out,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_data,
  output logic              undef,
  output logic              flush_req
);

  localparam int WIN_W = ADDR_W - PID_W;

  acc_kind_e        kind;
  logic [PID_W-1:0] acc_pid;
  logic [PID_W-1:0] xl_pid;
  logic             wr_en;
  logic             unused_low;

  assign unused_low = ^acc_wdata[WIN_W-1:0];
  assign wr_en      = (kind == ACC_WRITE);

  ctx_access_decode dec_i (
    .valid  (acc_valid),
    .write  (acc_write),
    .crn    (acc_crn),
    .crm    (acc_crm),
    .op1    (acc_op1),
    .op2    (acc_op2),
    .priv   (acc_priv),
    .nonsec (acc_nonsec),
    .lock   (sec_lock),
    .kind   (kind)
  );

  ctx_id_bank #(.PID_W(PID_W)) bank_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_world  (acc_nonsec),
    .wr_pid    (acc_wdata[ADDR_W-1 -: PID_W]),
    .acc_world (acc_nonsec),
    .xl_world  (va_nonsec),
    .acc_pid   (acc_pid),
    .xl_pid    (xl_pid)
  );

  ctx_addr_xlate #(.ADDR_W(ADDR_W), .PID_W(PID_W)) xlate_i (
    .clk (clk),
    .rst (rst),
    .va  (va_in),
    .pid (xl_pid),
    .mva (mva_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      undef     <= 1'b0;
      flush_req <= 1'b0;
    end else begin
      rd_valid  <= (kind == ACC_READ);
      undef     <= (kind == ACC_FAULT);
      flush_req <= wr_en;
      if (kind == ACC_READ)
        rd_data <= {acc_pid, {WIN_W{1'b0}}};
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!flush_req && !undef && !rd_valid)); // R1

  AST_FLUSH_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    flush_req |-> $past(acc_valid && acc_write && acc_priv)); // R8

  AST_USER_REJECTED: assert property (@(posedge clk) disable iff (rst)
    $past(acc_valid && !acc_priv) |-> (!rd_valid && !flush_req)); // R6

  AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    $past(acc_valid && acc_write && sec_lock && !acc_nonsec) |-> !flush_req); // R7

  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (rst)
    $countones({rd_valid, undef, flush_req}) <= 1); // R6

  AST_READ_FORMAT: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_data[WIN_W-1:0] == '0)); // R5

endmodule

// File: tb/ctx_slot_remap_tb_top.sv
module ctx_slot_remap_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] WIN = 32'h0200_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic        acc_write = 1'b0;
  logic [3:0]  acc_crn = 4'd0;
  logic [3:0]  acc_crm = 4'd0;
  logic [2:0]  acc_op1 = 3'd0;
  logic [2:0]  acc_op2 = 3'd0;
  logic        acc_priv = 1'b0;
  logic        acc_nonsec = 1'b0;
  logic [31:0] acc_wdata = '0;
  logic        sec_lock = 1'b0;
  logic [31:0] va_in = '0;
  logic        va_nonsec = 1'b0;
  logic [31:0] mva_out;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        undef;
  logic        flush_req;

  int total = 0;
  int bad = 0;
  logic [6:0] mpid [2];
  logic got_rv, got_un, got_fl;
  logic [31:0] got_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctx_slot_remap dut_i (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_crn(acc_crn), .acc_crm(acc_crm), .acc_op1(acc_op1), .acc_op2(acc_op2),
    .acc_priv(acc_priv), .acc_nonsec(acc_nonsec), .acc_wdata(acc_wdata),
    .sec_lock(sec_lock), .va_in(va_in), .va_nonsec(va_nonsec),
    .mva_out(mva_out), .rd_valid(rd_valid), .rd_data(rd_data),
    .undef(undef), .flush_req(flush_req)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic access(input logic wr, input logic priv, input logic ns,
                        input logic [3:0] crn, input logic [3:0] crm,
                        input logic [2:0] o1, input logic [2:0] o2,
                        input logic [31:0] data);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_priv = priv; acc_nonsec = ns;
    acc_crn = crn; acc_crm = crm; acc_op1 = o1; acc_op2 = o2; acc_wdata = data;
    @(negedge clk);
    got_rv = rd_valid; got_un = undef; got_fl = flush_req; got_rd = rd_data;
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  function automatic logic [31:0] model(input logic [31:0] va, input logic ns);
    if (va < WIN) return va + {25'd0, mpid[ns]} * WIN;
    return va;
  endfunction

  task automatic xl(input string req, input logic [31:0] va, input logic ns);
    @(negedge clk);
    va_in = va; va_nonsec = ns;
    @(negedge clk);
    chk(req, mva_out, model(va, ns));
  endtask

  task automatic read_back(input string req, input logic ns);
    access(1'b0, 1'b1, ns, 4'd13, 4'd0, 3'd0, 3'd0, '0);
    chk({req, " rd_valid"}, {31'd0, got_rv}, 32'd1);
    chk({req, " rd_data"}, got_rd, {mpid[ns], 25'd0});
  endtask

  task automatic t_reset;
    chk("R1 flush", {31'd0, flush_req}, 32'd0);
    chk("R1 undef", {31'd0, undef}, 32'd0);
    chk("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    xl("R1 flat secure", 32'h0123_4567, 1'b0);
    xl("R1 flat nonsecure", 32'h01FF_FFFF, 1'b1);
    read_back("R1 secure copy", 1'b0);
  endtask

  task automatic t_write_translate;
    access(1'b1, 1'b1, 1'b0, 4'd13, 4'd0, 3'd0, 3'd0, 32'h0A00_1234);
    mpid[0] = 7'd5;
    chk("R8 flush on write", {31'd0, got_fl}, 32'd1);
    @(negedge clk);
    chk("R8 flush one cycle", {31'd0, flush_req}, 32'd0);
    xl("R2 low window", 32'h0000_0040, 1'b0);
    xl("R2 window top", 32'h01FF_FFFF, 1'b0);
    xl("R3 boundary", 32'h0200_0000, 1'b0);
    xl("R3 high", 32'hF000_0010, 1'b0);
    xl("R4 other copy untouched", 32'h0000_0040, 1'b1);
    read_back("R5 secure", 1'b0);
    access(1'b1, 1'b1, 1'b1, 4'd13, 4'd0, 3'd0, 3'd0, 32'hFE00_0000);
    mpid[1] = 7'd127;
    xl("R4 nonsecure max", 32'h0100_0000, 1'b1);
    xl("R4 secure kept", 32'h0100_0000, 1'b0);
    read_back("R5 nonsecure", 1'b1);
  endtask

  task automatic t_user;
    access(1'b1, 1'b0, 1'b0, 4'd13, 4'd0, 3'd0, 3'd0, 32'h2000_0000);
    chk("R6 undef on user write", {31'd0, got_un}, 32'd1);
    chk("R6 no flush", {31'd0, got_fl}, 32'd0);
    access(1'b0, 1'b0, 1'b1, 4'd13, 4'd0, 3'd0, 3'd0, '0);
    chk("R6 undef on user read", {31'd0, got_un}, 32'd1);
    chk("R6 no rd_valid", {31'd0, got_rv}, 32'd0);
    xl("R6 secure unchanged", 32'h0000_0100, 1'b0);
  endtask

  task automatic t_lock;
    sec_lock = 1'b1;
    access(1'b1, 1'b1, 1'b0, 4'd13, 4'd0, 3'd0, 3'd0, 32'h4000_0000);
    chk("R7 undef locked", {31'd0, got_un}, 32'd1);
    chk("R7 no flush", {31'd0, got_fl}, 32'd0);
    xl("R7 secure unchanged", 32'h0000_0200, 1'b0);
    access(1'b1, 1'b1, 1'b1, 4'd13, 4'd0, 3'd0, 3'd0, 32'h0600_0000);
    mpid[1] = 7'd3;
    chk("R7 nonsecure write ok", {31'd0, got_fl}, 32'd1);
    read_back("R7 secure read ok", 1'b0);
    sec_lock = 1'b0;
  endtask

  task automatic t_other_sel;
    access(1'b1, 1'b1, 1'b0, 4'd13, 4'd0, 3'd0, 3'd2, 32'hFE00_0000);
    chk("R9 op2 no flush", {31'd0, got_fl}, 32'd0);
    chk("R9 op2 no undef", {31'd0, got_un}, 32'd0);
    access(1'b1, 1'b1, 1'b0, 4'd12, 4'd0, 3'd0, 3'd0, 32'hFE00_0000);
    chk("R9 crn no flush", {31'd0, got_fl}, 32'd0);
    access(1'b0, 1'b1, 1'b0, 4'd13, 4'd1, 3'd0, 3'd0, '0);
    chk("R9 crm no rd_valid", {31'd0, got_rv}, 32'd0);
    access(1'b0, 1'b1, 1'b0, 4'd13, 4'd0, 3'd1, 3'd0, '0);
    chk("R9 op1 no rd_valid", {31'd0, got_rv}, 32'd0);
    xl("R9 secure unchanged", 32'h0000_0300, 1'b0);
  endtask

  task automatic t_sweep;
    for (int p = 0; p < 128; p++) begin
      access(1'b1, 1'b1, 1'b0, 4'd13, 4'd0, 3'd0, 3'd0, {p[6:0], 25'h0AB});
      mpid[0] = p[6:0];
      xl("R2 sweep", 32'h01FF_FFFF, 1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    mpid[0] = '0; mpid[1] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_write_translate();
    t_user();
    t_lock();
    t_other_sel();
    t_sweep();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule